// File: doc/BRIEF.md
# Parallel SRAM and FIFO Memory Test Controller

This block is a self-test sequencer for memories that sit on a parallel address and data bus. A two-bit test selector chooses the target, and a one-cycle start pulse launches the run. For static RAM targets the controller performs a five-access-per-word march over an abstract memory. An abstract memory is a group of devices that share one address range and one control interface, each supplying its own slice of the data bus; here there are two devices of independently parameterised width. A dual-ported RAM is covered by running the same march on port 0 and then on port 1.

FIFO devices are handled as two separate targets. One selector value makes the controller write a fixed pattern into the FIFO. Another selector value makes it read that many words back, check each word against the pattern, and watch the FIFO's full and empty flags. Every run ends with a one-cycle done pulse. The outcome stays visible afterwards as a held fail indication (with per-device lanes, the first failing address and the first failing port) and as a three-bit flag-status word.

Top module: `mem_test_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, doneIrq, memWe, memRe, failSticky, failLanes and flagStatus are all 0.
- R2: Selector 0 (single-port RAM) issues exactly 5n accesses for n = 2^ADDR_W words, in three passes. The first pass goes up from address 0 writing all zeros. The second goes up, and at each address reads (expecting zeros) and then writes all ones. The third goes down from address n-1, and at each address reads (expecting ones) and then writes all zeros. memWe and memRe are never high together.
- R3: Read data is taken from memRData in the cycle after memRe. Any bit that differs from the expected pattern sets failSticky. failAddr and failPort hold the address and port of the first mismatch of the run.
- R4: failLanes bit 0 flags a mismatch in data bits [DEV0_W-1:0] (device 0), and bit 1 flags a mismatch in the bits above them (device 1). The lanes accumulate over the run.
- R5: Selector 1 (dual-port RAM) runs the full R2 march with memPort = 0 and then again with memPort = 1, for 10n accesses. Selector 0 keeps memPort at 0.
- R6: Selector 2 (FIFO fill) issues FIFO_DEPTH writes, with data all ones if fillOnes was 1 at start and all zeros otherwise. flagStatus bit 0 takes fifoFull as sampled in the cycle after the last write.
- R7: Selector 3 (FIFO drain) issues FIFO_DEPTH reads and checks each one against the pattern chosen by fillOnes. memAddr carries the read index. flagStatus bit 1 takes fifoEmpty in the cycle after the last read. flagStatus bit 2 is set if fifoEmpty is high in any drain read cycle.
- R8: doneIrq is a single-cycle pulse. For RAM tests it comes in the cycle after the last access. For FIFO tests it comes two cycles after the last access. At that moment the fail and flag outputs already hold the final result. busy is high from the cycle after start up to and including the done cycle.
- R9: A start pulse that arrives while busy is ignored: the running test keeps its selector, sequence and length.
- R10: An accepted start clears failSticky, failLanes, failAddr and failPort. A fill start clears all flagStatus bits. A drain start clears bits 2 and 1 and keeps bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startPulse | input | 1 | Launches a test when idle |
| memId | input | 2 | Test selector: 0 RAM, 1 dual-port RAM, 2 FIFO fill, 3 FIFO drain |
| fillOnes | input | 1 | FIFO pattern select, 1 = all ones |
| memAddr | output | ADDR_W | Memory address / FIFO word index |
| memPort | output | 1 | Port under test for dual-port RAM |
| memWe | output | 1 | Write strobe |
| memRe | output | 1 | Read strobe |
| memWData | output | DATA_W | Write data |
| memRData | input | DATA_W | Read data, valid the cycle after memRe |
| fifoFull | input | 1 | FIFO full flag |
| fifoEmpty | input | 1 | FIFO empty flag |
| busy | output | 1 | Test in progress |
| doneIrq | output | 1 | One-cycle completion pulse |
| failSticky | output | 1 | Mismatch seen during the run |
| failLanes | output | 2 | Per-device mismatch flags |
| failAddr | output | ADDR_W | Address of first mismatch |
| failPort | output | 1 | Port of first mismatch |
| flagStatus | output | 3 | bit0 full after fill, bit1 empty after drain, bit2 early empty |

## Verification
Some properties are checked by assertions on every cycle. These are: read and write strobes never overlap, done lasts exactly one cycle, the latched selector cannot change during a run, a fail can only appear two cycles after a read, and the early-empty flag can only rise after a drain read that saw empty. Other properties can only be shown by the bench scenarios, which drive a RAM model with injected stuck bits and a FIFO model of adjustable capacity. These are: the exact march order and access count, port sequencing, the first-failure address and port, the per-device lanes, the flag values and their clearing rules, and the rejection of a start during a run.

// File: rtl/mtc_pkg.sv
package mtc_pkg;

  typedef enum logic [1:0] {
    ID_SRAM       = 2'd0,
    ID_SRAM_DUAL  = 2'd1,
    ID_FIFO_FILL  = 2'd2,
    ID_FIFO_DRAIN = 2'd3
  } testId_e;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_W0,
    PH_R0W1,
    PH_R1W0,
    PH_FILL,
    PH_DRAIN,
    PH_SETTLE,
    PH_DONE
  } phase_e;

  // strobes from the sequencer to the datapath, one set per cycle
  typedef struct packed {
    logic wrEn;
    logic rdEn;
    logic wrOnes;
    logic expOnes;
    logic drainRd;
    logic sampleFull;
    logic sampleEmpty;
    logic clrFail;
    logic clrAllFlags;
    logic clrDrainFlags;
  } ctrlStrobe_t;

endpackage

// File: rtl/mtc_ctrl.sv
module mtc_ctrl
  import mtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int FIFO_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        memId,
  input  logic              fillOnes,
  output ctrlStrobe_t       strobe,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memPort,
  output logic              busy,
  output logic              doneIrq
);

  localparam int FIFO_W = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;
  localparam int CNT_W  = (ADDR_W > FIFO_W) ? ADDR_W : FIFO_W;
  localparam logic [CNT_W-1:0] ADDR_LAST = CNT_W'((2 ** ADDR_W) - 1);
  localparam logic [CNT_W-1:0] FIFO_LAST = CNT_W'(FIFO_DEPTH - 1);

  phase_e           phase;
  testId_e          runId;
  logic [CNT_W-1:0] cnt;
  logic             subStep;
  logic             portReg;
  logic             fillPat;
  testId_e          reqId;

  assign reqId = testId_e'(memId);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      runId   <= ID_SRAM;
      cnt     <= '0;
      subStep <= 1'b0;
      portReg <= 1'b0;
      fillPat <= 1'b0;
    end else begin
      unique case (phase)
        PH_IDLE: begin
          if (startPulse) begin
            runId   <= reqId;
            fillPat <= fillOnes;
            cnt     <= '0;
            subStep <= 1'b0;
            portReg <= 1'b0;
            if (reqId == ID_FIFO_FILL)       phase <= PH_FILL;
            else if (reqId == ID_FIFO_DRAIN) phase <= PH_DRAIN;
            else                             phase <= PH_W0;
          end
        end
        PH_W0: begin
          if (cnt == ADDR_LAST) begin
            cnt   <= '0;
            phase <= PH_R0W1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        PH_R0W1: begin
          subStep <= ~subStep;
          if (subStep) begin
            if (cnt == ADDR_LAST) phase <= PH_R1W0;
            else                  cnt   <= cnt + 1'b1;
          end
        end
        PH_R1W0: begin
          subStep <= ~subStep;
          if (subStep) begin
            if (cnt == '0) begin
              if (runId == ID_SRAM_DUAL && !portReg) begin
                portReg <= 1'b1;
                phase   <= PH_W0;
              end else begin
                phase <= PH_DONE;
              end
            end else begin
              cnt <= cnt - 1'b1;
            end
          end
        end
        PH_FILL, PH_DRAIN: begin
          if (cnt == FIFO_LAST) phase <= PH_SETTLE;
          else                  cnt   <= cnt + 1'b1;
        end
        PH_SETTLE: phase <= PH_DONE;
        PH_DONE:   phase <= PH_IDLE;
        default:   phase <= PH_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe = '0;
    unique case (phase)
      PH_IDLE: begin
        if (startPulse) begin
          strobe.clrFail       = 1'b1;
          strobe.clrAllFlags   = (reqId == ID_FIFO_FILL);
          strobe.clrDrainFlags = (reqId == ID_FIFO_DRAIN);
        end
      end
      PH_W0: strobe.wrEn = 1'b1;
      PH_R0W1: begin
        strobe.rdEn   = ~subStep;
        strobe.wrEn   = subStep;
        strobe.wrOnes = 1'b1;
      end
      PH_R1W0: begin
        strobe.rdEn    = ~subStep;
        strobe.wrEn    = subStep;
        strobe.expOnes = 1'b1;
      end
      PH_FILL: begin
        strobe.wrEn   = 1'b1;
        strobe.wrOnes = fillPat;
      end
      PH_DRAIN: begin
        strobe.rdEn    = 1'b1;
        strobe.drainRd = 1'b1;
        strobe.expOnes = fillPat;
      end
      PH_SETTLE: begin
        strobe.sampleFull  = (runId == ID_FIFO_FILL);
        strobe.sampleEmpty = (runId == ID_FIFO_DRAIN);
      end
      default: ;
    endcase
  end

  assign memAddr = cnt[ADDR_W-1:0];
  assign memPort = portReg;
  assign busy    = (phase != PH_IDLE);
  assign doneIrq = (phase == PH_DONE);

  // R2
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strobe.wrEn && strobe.rdEn));

  // R8
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |=> !doneIrq);

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneIrq |-> $past(busy));

  // R9
  id_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> $stable(runId));

endmodule

// File: rtl/mtc_datapath.sv
module mtc_datapath
  import mtc_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DEV0_W = 8,
  parameter int DEV1_W = 4,
  parameter int DATA_W = DEV0_W + DEV1_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  input  logic [ADDR_W-1:0] memAddr,
  input  logic              memPort,
  input  logic [DATA_W-1:0] memRData,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWData,
  output logic              failSticky,
  output logic [1:0]        failLanes,
  output logic [ADDR_W-1:0] failAddr,
  output logic              failPort,
  output logic [2:0]        flagStatus
);

  localparam int NUM_DEV = 2;

  logic              cmpValid;
  logic              cmpExp;
  logic [ADDR_W-1:0] cmpAddr;
  logic              cmpPort;
  logic [DATA_W-1:0] diffBits;
  logic [NUM_DEV-1:0] laneBad;

  assign memWe    = strobe.wrEn;
  assign memRe    = strobe.rdEn;
  assign memWData = {DATA_W{strobe.wrOnes}};

  // read data returns one cycle after the strobe
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpValid <= 1'b0;
      cmpExp   <= 1'b0;
      cmpAddr  <= '0;
      cmpPort  <= 1'b0;
    end else begin
      cmpValid <= strobe.rdEn;
      cmpExp   <= strobe.expOnes;
      cmpAddr  <= memAddr;
      cmpPort  <= memPort;
    end
  end

  assign diffBits = memRData ^ {DATA_W{cmpExp}};

  for (genvar d = 0; d < NUM_DEV; d++) begin : g_lane
    localparam int LO = (d == 0) ? 0 : DEV0_W;
    localparam int WD = (d == 0) ? DEV0_W : DEV1_W;
    assign laneBad[d] = cmpValid && (|diffBits[LO +: WD]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      failSticky <= 1'b0;
      failLanes  <= '0;
      failAddr   <= '0;
      failPort   <= 1'b0;
    end else if (strobe.clrFail) begin
      failSticky <= 1'b0;
      failLanes  <= '0;
      failAddr   <= '0;
      failPort   <= 1'b0;
    end else if (|laneBad) begin
      if (!failSticky) begin
        failAddr <= cmpAddr;
        failPort <= cmpPort;
      end
      failSticky <= 1'b1;
      failLanes  <= failLanes | laneBad;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagStatus <= '0;
    end else if (strobe.clrAllFlags) begin
      flagStatus <= '0;
    end else if (strobe.clrDrainFlags) begin
      flagStatus[2:1] <= 2'b00;
    end else begin
      if (strobe.sampleFull)            flagStatus[0] <= fifoFull;
      if (strobe.sampleEmpty)           flagStatus[1] <= fifoEmpty;
      if (strobe.drainRd && fifoEmpty)  flagStatus[2] <= 1'b1;
    end
  end

  // R3
  fail_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(failSticky) |-> $past(strobe.rdEn, 2));

  // R7
  early_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(flagStatus[2]) |-> $past(strobe.drainRd && fifoEmpty));

  // R4
  lane_fail_chk: assert property (@(posedge clk) disable iff (!rstN)
    (failLanes != '0) |-> failSticky);

endmodule

// File: rtl/mem_test_ctrl.sv
module mem_test_ctrl
  import mtc_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int DEV0_W     = 8,
  parameter int DEV1_W     = 4,
  parameter int FIFO_DEPTH = 8,
  parameter int DATA_W     = DEV0_W + DEV1_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startPulse,
  input  logic [1:0]        memId,
  input  logic              fillOnes,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memPort,
  output logic              memWe,
  output logic              memRe,
  output logic [DATA_W-1:0] memWData,
  input  logic [DATA_W-1:0] memRData,
  input  logic              fifoFull,
  input  logic              fifoEmpty,
  output logic              busy,
  output logic              doneIrq,
  output logic              failSticky,
  output logic [1:0]        failLanes,
  output logic [ADDR_W-1:0] failAddr,
  output logic              failPort,
  output logic [2:0]        flagStatus
);

  ctrlStrobe_t strobe;

  mtc_ctrl #(
    .ADDR_W     (ADDR_W),
    .FIFO_DEPTH (FIFO_DEPTH)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startPulse (startPulse),
    .memId      (memId),
    .fillOnes   (fillOnes),
    .strobe     (strobe),
    .memAddr    (memAddr),
    .memPort    (memPort),
    .busy       (busy),
    .doneIrq    (doneIrq)
  );

  mtc_datapath #(
    .ADDR_W (ADDR_W),
    .DEV0_W (DEV0_W),
    .DEV1_W (DEV1_W),
    .DATA_W (DATA_W)
  ) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .memAddr    (memAddr),
    .memPort    (memPort),
    .memRData   (memRData),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .memWe      (memWe),
    .memRe      (memRe),
    .memWData   (memWData),
    .failSticky (failSticky),
    .failLanes  (failLanes),
    .failAddr   (failAddr),
    .failPort   (failPort),
    .flagStatus (flagStatus)
  );

endmodule

// File: tb/tb_mem_test_ctrl.sv
`timescale 1ns/1ps
module tb_mem_test_ctrl;

  localparam int ADDR_W = 4;
  localparam int DW     = 12;
  localparam int N      = 16;
  localparam int FD     = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startPulse = 1'b0;
  logic [1:0] memId = 2'd0;
  logic fillOnes = 1'b0;
  logic [ADDR_W-1:0] memAddr;
  logic memPort, memWe, memRe, busy, doneIrq, failSticky, failPort;
  logic [DW-1:0] memWData;
  logic [DW-1:0] memRData;
  logic fifoFull, fifoEmpty;
  logic [1:0] failLanes;
  logic [ADDR_W-1:0] failAddr;
  logic [2:0] flagStatus;

  always #5 clk = ~clk;

  mem_test_ctrl dut (
    .clk(clk), .rstN(rstN), .startPulse(startPulse), .memId(memId),
    .fillOnes(fillOnes), .memAddr(memAddr), .memPort(memPort),
    .memWe(memWe), .memRe(memRe), .memWData(memWData), .memRData(memRData),
    .fifoFull(fifoFull), .fifoEmpty(fifoEmpty), .busy(busy),
    .doneIrq(doneIrq), .failSticky(failSticky), .failLanes(failLanes),
    .failAddr(failAddr), .failPort(failPort), .flagStatus(flagStatus)
  );

  // ---------------- memory models ----------------
  logic [DW-1:0] sram [2][N];
  logic [DW-1:0] fifoMem [16];
  logic [4:0] fifoCnt = 5'd0;
  logic [3:0] wrPtr = 4'd0, rdPtr = 4'd0;
  logic [4:0] fifoCap = 5'd8;
  logic fifoMode = 1'b0;
  logic stuckEn = 1'b0, stuckPort = 1'b0, stuckVal = 1'b0;
  logic [ADDR_W-1:0] stuckAddr = '0;
  int stuckBit = 0;
  // 0 none, 1 clear fifo, 2 preload FD words of ones, 3 corrupt word 2 bit 10
  int fifoCmd = 0;
  logic [DW-1:0] rdReg = '0;

  assign memRData  = rdReg;
  assign fifoFull  = (fifoCnt == fifoCap);
  assign fifoEmpty = (fifoCnt == 5'd0);

  always @(posedge clk) begin
    if (fifoCmd == 1) begin
      fifoCnt <= 0; wrPtr <= 0; rdPtr <= 0;
    end else if (fifoCmd == 2) begin
      for (int i = 0; i < FD; i++) fifoMem[i] <= '1;
      fifoCnt <= 5'(FD); wrPtr <= 4'(FD); rdPtr <= 0;
    end else if (fifoCmd == 3) begin
      fifoMem[rdPtr + 4'd2] <= fifoMem[rdPtr + 4'd2] ^ DW'(1 << 10);
    end else if (fifoMode) begin
      if (memWe && fifoCnt < fifoCap) begin
        fifoMem[wrPtr] <= memWData;
        wrPtr <= wrPtr + 1'b1;
      end
      if (memRe) begin
        if (fifoCnt != 0) begin
          rdReg <= fifoMem[rdPtr];
          rdPtr <= rdPtr + 1'b1;
        end else begin
          rdReg <= '0;
        end
      end
      fifoCnt <= fifoCnt + 5'((memWe && fifoCnt < fifoCap) ? 1 : 0)
                         - 5'((memRe && fifoCnt != 0) ? 1 : 0);
    end else begin
      if (memWe) sram[memPort][memAddr] <= memWData;
      if (memRe) begin
        logic [DW-1:0] v;
        v = sram[memPort][memAddr];
        if (stuckEn && memPort == stuckPort && memAddr == stuckAddr)
          v[stuckBit] = stuckVal;
        rdReg <= v;
      end
    end
  end

  // ---------------- march trace monitor ----------------
  logic traceOn = 1'b0;
  int traceIdx = 0;
  int traceErr = 0;

  always @(negedge clk) begin
    if (!traceOn) begin
      traceIdx = 0;
      traceErr = 0;
    end else if (memWe || memRe) begin
      int p, k, j, ea;
      logic ew, er;
      logic [DW-1:0] ed;
      p = traceIdx / (5 * N);
      k = traceIdx % (5 * N);
      ew = 0; er = 0; ed = '0; ea = 0;
      if (k < N) begin
        ew = 1; ea = k; ed = '0;
      end else if (k < 3 * N) begin
        j = k - N; ea = j / 2;
        if (j % 2 == 0) er = 1; else begin ew = 1; ed = '1; end
      end else begin
        j = k - 3 * N; ea = N - 1 - j / 2;
        if (j % 2 == 0) er = 1; else begin ew = 1; ed = '0; end
      end
      if (memWe != ew || memRe != er || int'(memAddr) != ea ||
          int'(memPort) != p || (ew && memWData != ed))
        traceErr++;
      traceIdx++;
    end
  end

  // ---------------- checking ----------------
  int checks = 0;
  int fails = 0;
  bit finished = 0;

  task automatic check(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic fifoDo(input int cmd);
    fifoCmd = cmd;
    @(negedge clk);
    fifoCmd = 0;
  endtask

  // starts a test at a negedge, optionally pulses start again at cycle injectAt
  task automatic runTest(input logic [1:0] id, input logic ones, input int injectAt,
                         output int cycles);
    memId = id;
    fillOnes = ones;
    startPulse = 1'b1;
    @(negedge clk);
    startPulse = 1'b0;
    cycles = 1;
    while (!doneIrq && cycles < 2000) begin
      if (cycles == injectAt) begin
        memId = 2'd3; startPulse = 1'b1;
      end else begin
        startPulse = 1'b0;
      end
      @(negedge clk);
      cycles++;
    end
    startPulse = 1'b0;
  endtask

  task automatic checkDoneDrops(input string tag);
    @(negedge clk);
    check(!doneIrq && !busy, tag, {doneIrq, busy}, 0);
  endtask

  task automatic testReset;
    // R1
    check(!busy && !doneIrq && !memWe && !memRe, "R1 strobes",
          {busy, doneIrq, memWe, memRe}, 0);
    check(!failSticky && failLanes == 0 && flagStatus == 0, "R1 status",
          {failSticky, failLanes, flagStatus}, 0);
  endtask

  task automatic testCleanSingle;
    int cyc;
    traceOn = 1;
    runTest(2'd0, 1'b0, 0, cyc);
    // R2 sequence and count
    check(traceErr == 0 && traceIdx == 5 * N, "R2 march order",
          traceIdx, 5 * N);
    // R8 timing
    check(cyc == 5 * N + 1, "R8 done cycle", cyc, 5 * N + 1);
    check(!failSticky, "R3 clean", failSticky, 0);
    traceOn = 0;
    checkDoneDrops("R8 done width");
  endtask

  task automatic testStuckHigh;
    int cyc;
    stuckEn = 1; stuckPort = 0; stuckAddr = 4'd3; stuckBit = 0; stuckVal = 1;
    runTest(2'd0, 1'b0, 0, cyc);
    // R3 first fail in ascending read-zero pass at address 3
    check(failSticky && failAddr == 4'd3 && failPort == 0, "R3 first fail",
          {failSticky, failPort, failAddr}, {1'b1, 1'b0, 4'd3});
    // R4 device 0 lane
    check(failLanes == 2'b01, "R4 lane dev0", failLanes, 2'b01);
    stuckEn = 0;
    checkDoneDrops("R8 done width");
  endtask

  task automatic testDualStuckLow;
    int cyc;
    // clean run first clears old fail (R10)
    runTest(2'd0, 1'b0, 0, cyc);
    check(!failSticky && failLanes == 0, "R10 fail cleared",
          {failSticky, failLanes}, 0);
    checkDoneDrops("R8 done width");
    stuckEn = 1; stuckPort = 1; stuckAddr = 4'd5; stuckBit = 9; stuckVal = 0;
    traceOn = 1;
    runTest(2'd1, 1'b0, 0, cyc);
    // R5 two ports in order
    check(traceErr == 0 && traceIdx == 10 * N, "R5 dual sequence",
          traceIdx, 10 * N);
    check(cyc == 10 * N + 1, "R5 dual length", cyc, 10 * N + 1);
    check(failSticky && failAddr == 4'd5 && failPort == 1, "R3 dual fail",
          {failSticky, failPort, failAddr}, {1'b1, 1'b1, 4'd5});
    // R4 device 1 lane
    check(failLanes == 2'b10, "R4 lane dev1", failLanes, 2'b10);
    traceOn = 0; stuckEn = 0;
    checkDoneDrops("R8 done width");
  endtask

  task automatic testIgnoreStart;
    int cyc;
    logic [2:0] flagsBefore;
    flagsBefore = flagStatus;
    traceOn = 1;
    runTest(2'd0, 1'b0, 20, cyc);
    // R9
    check(traceErr == 0 && traceIdx == 5 * N, "R9 run unchanged", traceIdx, 5 * N);
    check(cyc == 5 * N + 1, "R9 length unchanged", cyc, 5 * N + 1);
    check(flagStatus == flagsBefore, "R9 flags untouched", flagStatus, flagsBefore);
    traceOn = 0;
    checkDoneDrops("R9 idle after");
  endtask

  task automatic testFifoNormal;
    int cyc;
    fifoMode = 1; fifoCap = 5'(FD);
    fifoDo(1);
    runTest(2'd2, 1'b1, 0, cyc);
    // R6
    check(cyc == FD + 2, "R6 fill length", cyc, FD + 2);
    check(flagStatus == 3'b001, "R6 full seen", flagStatus, 3'b001);
    check(fifoCnt == 5'(FD) && fifoMem[0] == '1, "R6 fill data",
          {fifoCnt, fifoMem[0]}, {5'(FD), 12'hfff});
    checkDoneDrops("R8 done width");
    runTest(2'd3, 1'b1, 0, cyc);
    // R7
    check(cyc == FD + 2 && !failSticky, "R7 drain clean", {cyc, failSticky}, FD + 2);
    check(flagStatus == 3'b011, "R7 empty at end", flagStatus, 3'b011);
    checkDoneDrops("R8 done width");
  endtask

  task automatic testFifoSmall;
    int cyc;
    fifoCap = 5'd6;
    fifoDo(1);
    runTest(2'd2, 1'b1, 0, cyc);
    check(flagStatus == 3'b001, "R6 full on small fifo", flagStatus, 3'b001);
    checkDoneDrops("R8 done width");
    runTest(2'd3, 1'b1, 0, cyc);
    // R7 early empty at read index 6, all-zero data returned
    check(flagStatus == 3'b111, "R7 early empty", flagStatus, 3'b111);
    check(failSticky && failAddr == 4'd6 && failLanes == 2'b11, "R7 drain fail",
          {failSticky, failAddr, failLanes}, {1'b1, 4'd6, 2'b11});
    checkDoneDrops("R8 done width");
    // R10 drain clears bits 2:1 but keeps bit 0
    fifoCap = 5'(FD);
    fifoDo(2);
    runTest(2'd3, 1'b1, 0, cyc);
    check(flagStatus == 3'b011 && !failSticky, "R10 drain clear",
          {failSticky, flagStatus}, 3'b011);
    checkDoneDrops("R8 done width");
  endtask

  task automatic testFifoOverCap;
    int cyc;
    fifoCap = 5'd10;
    fifoDo(1);
    runTest(2'd2, 1'b0, 0, cyc);
    // R10 fill clears all flags; R6 full not reached
    check(flagStatus == 3'b000, "R10 fill clear / R6 not full", flagStatus, 3'b000);
    check(fifoMem[0] == '0, "R6 zero pattern", fifoMem[0], 0);
    checkDoneDrops("R8 done width");
    fifoCap = 5'(FD);
    fifoDo(1);
    runTest(2'd2, 1'b0, 0, cyc);
    checkDoneDrops("R8 done width");
    fifoDo(3);
    runTest(2'd3, 1'b0, 0, cyc);
    // R7 corrupted word 2, bit 10 in device 1
    check(failSticky && failAddr == 4'd2 && failLanes == 2'b10, "R7 corrupt word",
          {failSticky, failAddr, failLanes}, {1'b1, 4'd2, 2'b10});
    check(flagStatus == 3'b011, "R7 flags normal", flagStatus, 3'b011);
    checkDoneDrops("R8 done width");
    fifoMode = 0;
  endtask

  task automatic finish_run;
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testCleanSingle();
    testStuckHigh();
    testDualStuckLow();
    testIgnoreStart();
    testFifoNormal();
    testFifoSmall();
    testFifoOverCap();
    repeat (2) @(negedge clk);
    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
    finish_run();
  end

endmodule